// File: doc/BRIEF.md
# Eight-Channel LED PWM Controller with Group Dimming and Blinking

This block drives eight active-low LED enables. Every channel has its own 8-bit fast pulse-width modulator. The modulators share one free-running 256-cycle counter, so all channels stay in phase. A second, slower group modulator sits above them. It either dims or blinks every channel whose mode selects group control.

Each channel picks one of four modes with a 2-bit field. The group modulator has two settings. In dimming it runs a slow fixed-period PWM. In blinking it runs a programmable-period on/off pattern. The blink period counts whole blink steps, and a parameter sets the number of clocks in one step, so a testbench can shrink the timebase. A sleep input stops all modulation and turns every LED off.

The asynchronous active-low reset is released through a two-flop synchronizer. All counters restart together when it is released.

Top module: `led_pwm_ctrl`

## Requirements
- R1: While reset is applied, and for the two clocks after its release, every `led_n` bit is 1. The first clock after that is phase 0 of every counter.
- R2: Mode code 00 (off) drives the channel's `led_n` to 1.
- R3: Mode code 01 (full on) drives `led_n` to 0 regardless of any duty, group or blink setting, while sleep is low.
- R4: Mode code 10 (individual) drives `led_n` low while the fast counter is below the channel duty D. The fast counter advances by one per awake clock and wraps after 255, which gives D active clocks in every 256.
- R5: A duty of 00h never turns the channel on in modes 10 and 11. A duty of FFh turns it on for 255 of every 256 fast phases.
- R6: Mode code 11 (grouped) is the individual PWM ANDed with a group gate. With the blink select at 0 (dimming), the gate is high while (group count >> DIM_SHIFT) < group duty. The group count wraps every 256 << DIM_SHIFT clocks, and DIM_SHIFT defaults to 9.
- R7: With the blink select at 1 (blinking), the blink period is P = (frequency byte + 1) × BLINK_STEP clocks. The gate is high while 256 × position < group duty × P.
- R8: While dimming, the frequency byte has no effect on any output.
- R9: While sleep is high, every `led_n` is 1 and all counters hold. When sleep drops, modulation resumes from the held phases.
- R10: `led_n` is registered. It reflects the inputs and counter phase of the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Stops modulation and turns all LEDs off |
| duty_flat | input | NCH*DW | Per-channel duty, channel i at bits [i*DW +: DW] |
| grp_duty | input | DW | Group duty byte |
| grp_freq | input | DW | Blink period byte |
| blink_sel | input | 1 | 0 = dimming, 1 = blinking |
| mode_flat | input | NCH*2 | Per-channel mode, channel i at bits [2i +: 2] |
| led_n | output | NCH | Active-low LED enables |

## Verification
The eight channels are given different roles at the same time: off, full on, mid duty, zero duty, full duty, and three grouped channels at different duties. One run therefore separates mode decoding from duty comparison. The group duty is swept through a middle value, zero and FFh in dimming, and the frequency byte is changed during dimming to show that it has no effect. Blinking is run with three period/duty pairs, including the shortest period. A sleep interval checks that phases are held and not reset. Every output is compared, clock by clock, with a behavioural model of the counters.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
  typedef enum logic [1:0] {
    CH_OFF = 2'b00,
    CH_ON  = 2'b01,
    CH_IND = 2'b10,
    CH_GRP = 2'b11
  } ch_mode_e;
endpackage

// File: rtl/led_fast_cnt.sv
module led_fast_cnt #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [DW-1:0] cnt
);
  logic [DW-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt;
    if (en) cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nx;
  end
endmodule

// File: rtl/led_group_gen.sv
module led_group_gen #(
  parameter int DW         = 8,
  parameter int DIM_SHIFT  = 9,
  parameter int BLINK_STEP = 1041667
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] gdc,
  input  logic [DW-1:0] gfrq,
  input  logic          blink_sel,
  output logic          gate
);
  localparam int DCW = DW + DIM_SHIFT;
  localparam int BW  = $clog2((2**DW) * BLINK_STEP);
  localparam int PW  = BW + DW + 1;

  logic [DCW-1:0] dcnt, dcnt_nx;
  logic [BW-1:0]  bcnt, bcnt_nx;
  logic [PW-1:0]  period;
  logic           dim_on, blink_on;

  always_comb begin
    period  = (PW'(gfrq) + PW'(1)) * PW'(BLINK_STEP);
    dcnt_nx = dcnt;
    bcnt_nx = bcnt;
    if (en) begin
      dcnt_nx = dcnt + 1'b1;
      if (PW'(bcnt) + PW'(1) >= period) bcnt_nx = '0;
      else                              bcnt_nx = bcnt + 1'b1;
    end
    dim_on   = dcnt[DCW-1:DIM_SHIFT] < gdc;
    blink_on = (PW'(bcnt) << DW) < (PW'(gdc) * period);
    gate     = blink_sel ? blink_on : dim_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;
      bcnt <= '0;
    end else begin
      dcnt <= dcnt_nx;
      bcnt <= bcnt_nx;
    end
  end
endmodule

// File: rtl/led_chan_drv.sv
module led_chan_drv
  import led_pwm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] phase,
  input  logic [DW-1:0] duty,
  input  ch_mode_e      mode,
  input  logic          gate,
  output logic          led_n
);
  logic ind_on, on_nx;

  always_comb begin
    ind_on = phase < duty;
    on_nx  = 1'b0;
    if (en) begin
      case (mode)
        CH_ON:   on_nx = 1'b1;
        CH_IND:  on_nx = ind_on;
        CH_GRP:  on_nx = ind_on & gate;
        default: on_nx = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_n <= 1'b1;
    else        led_n <= ~on_nx;
  end
endmodule

// File: rtl/led_pwm_ctrl.sv
module led_pwm_ctrl
  import led_pwm_pkg::*;
#(
  parameter int NCH        = 8,
  parameter int DW         = 8,
  parameter int DIM_SHIFT  = 9,
  parameter int BLINK_STEP = 1041667
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic [NCH*DW-1:0] duty_flat,
  input  logic [DW-1:0]     grp_duty,
  input  logic [DW-1:0]     grp_freq,
  input  logic              blink_sel,
  input  logic [NCH*2-1:0]  mode_flat,
  output logic [NCH-1:0]    led_n
);
  logic          rs1, rst_i;
  logic          awake;
  logic [DW-1:0] phase;
  logic          gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1   <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs1   <= 1'b1;
      rst_i <= rs1;
    end
  end

  assign awake = ~sleep;

  led_fast_cnt #(.DW(DW)) u_fast (
    .clk(clk), .rst_n(rst_i), .en(awake), .cnt(phase)
  );

  led_group_gen #(.DW(DW), .DIM_SHIFT(DIM_SHIFT), .BLINK_STEP(BLINK_STEP)) u_grp (
    .clk(clk), .rst_n(rst_i), .en(awake), .gdc(grp_duty), .gfrq(grp_freq),
    .blink_sel(blink_sel), .gate(gate)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    led_chan_drv #(.DW(DW)) u_drv (
      .clk(clk), .rst_n(rst_i), .en(awake), .phase(phase),
      .duty(duty_flat[i*DW +: DW]), .mode(ch_mode_e'(mode_flat[2*i +: 2])),
      .gate(gate), .led_n(led_n[i])
    );
  end
endmodule

// File: rtl/led_pwm_chk.sv
module led_pwm_chk #(
  parameter int NCH = 8,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_i,
  input logic              sleep,
  input logic [NCH*DW-1:0] duty_flat,
  input logic [DW-1:0]     grp_duty,
  input logic [NCH*2-1:0]  mode_flat,
  input logic [NCH-1:0]    led_n
);
  // R9
  sleep_dark_chk: assert property (@(posedge clk) disable iff (!rst_i)
    sleep |=> (&led_n));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R2
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_i)
      (mode_flat[2*i +: 2] == 2'b00) |=> led_n[i]);
    // R3
    mode_on_chk: assert property (@(posedge clk) disable iff (!rst_i)
      (mode_flat[2*i +: 2] == 2'b01 && !sleep) |=> !led_n[i]);
    // R5
    duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_i)
      (mode_flat[2*i+1] && duty_flat[i*DW +: DW] == '0) |=> led_n[i]);
    // R6
    grp_zero_chk: assert property (@(posedge clk) disable iff (!rst_i)
      (mode_flat[2*i +: 2] == 2'b11 && grp_duty == '0) |=> led_n[i]);
  end
endmodule

bind led_pwm_ctrl led_pwm_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_i(rst_i), .sleep(sleep), .duty_flat(duty_flat),
  .grp_duty(grp_duty), .mode_flat(mode_flat), .led_n(led_n)
);

// File: tb/sim_led_pwm_ctrl.sv
module sim_led_pwm_ctrl;
  localparam int NCH = 8, DW = 8, DS = 2, STEP = 4;

  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0, blink_sel = 1'b0;
  logic [NCH*DW-1:0] duty_flat = '0;
  logic [DW-1:0] grp_duty = 8'hFF, grp_freq = 8'h00;
  logic [NCH*2-1:0] mode_flat = '0;
  logic [NCH-1:0] led_n;

  int total = 0, bad = 0;
  bit r8_phase = 0;

  always #10 clk = ~clk;

  led_pwm_ctrl #(.NCH(NCH), .DW(DW), .DIM_SHIFT(DS), .BLINK_STEP(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .duty_flat(duty_flat),
    .grp_duty(grp_duty), .grp_freq(grp_freq), .blink_sel(blink_sel),
    .mode_flat(mode_flat), .led_n(led_n)
  );

  // behavioural model: counters as integers, output one clock late (R10)
  int fc = 0, dc = 0, bc = 0;
  bit s1 = 0, s2 = 0;
  logic [NCH-1:0] exp_n = '1;
  string tag [NCH];

  initial for (int i = 0; i < NCH; i++) tag[i] = "R1";

  always @(posedge clk) begin
    bit act, g;
    int per;
    if (!rst_n) begin
      s1 = 0; s2 = 0; exp_n = '1; fc = 0; dc = 0; bc = 0;
      for (int i = 0; i < NCH; i++) tag[i] = "R1";
    end else begin
      act = s2; s2 = s1; s1 = 1;
      if (!act) begin
        exp_n = '1; fc = 0; dc = 0; bc = 0;
        for (int i = 0; i < NCH; i++) tag[i] = "R1";
      end else if (sleep) begin
        exp_n = '1;
        for (int i = 0; i < NCH; i++) tag[i] = "R9";
      end else begin
        per = (int'(grp_freq) + 1) * STEP;
        g = blink_sel ? (bc * 256 < int'(grp_duty) * per)
                      : ((dc >> DS) < int'(grp_duty));
        for (int i = 0; i < NCH; i++) begin
          int d;
          bit on;
          d = int'(duty_flat[i*DW +: DW]);
          case (mode_flat[2*i +: 2])
            2'b00: begin on = 0; tag[i] = "R2"; end
            2'b01: begin on = 1; tag[i] = "R3"; end
            2'b10: begin on = fc < d; tag[i] = (d == 0 || d == 255) ? "R5" : "R4"; end
            default: begin
              on = (fc < d) && g;
              tag[i] = blink_sel ? "R7" : (r8_phase ? "R8" : "R6");
            end
          endcase
          exp_n[i] = ~on;
        end
        fc = (fc + 1) % 256;
        dc = (dc + 1) % (256 << DS);
        bc = (bc + 1 >= per) ? 0 : bc + 1;
      end
    end
  end

  always @(negedge clk) begin
    for (int i = 0; i < NCH; i++) begin
      total++;
      if (led_n[i] !== exp_n[i]) begin
        bad++;
        $display("FAIL %s ch%0d t=%0t led_n=%b exp=%b", tag[i], i, $time, led_n[i], exp_n[i]);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic got, input logic want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, want);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: outputs dark in reset and during synchronizer release
    tick(3);
    chk("R1", &led_n, 1'b1);
    rst_n = 1'b1;
    mode_flat = 16'h5555;  // all channels full on
    tick(1);
    chk("R1", &led_n, 1'b1);
    tick(2);
    chk("R3", |led_n, 1'b0);

    // R10: change lands only after the next edge
    mode_flat[1:0] = 2'b00;
    #2 chk("R10", led_n[0], 1'b0);
    tick(1);
    chk("R10", led_n[0], 1'b1);

    // channel roles: off, on, ind 40, ind 00, ind FF, grp 80, grp FF, grp 10
    duty_flat = {8'h10, 8'hFF, 8'h80, 8'hFF, 8'h00, 8'h40, 8'h00, 8'h00};
    mode_flat = {2'b11, 2'b11, 2'b11, 2'b10, 2'b10, 2'b10, 2'b01, 2'b00};
    grp_duty = 8'h80;
    tick(2100);
    r8_phase = 1; grp_freq = 8'h5A;  // R8: frequency ignored while dimming
    tick(1100);
    grp_freq = 8'h03;
    tick(600);
    r8_phase = 0;
    grp_duty = 8'h00; tick(600);
    grp_duty = 8'hFF; tick(1100);

    // R7 blinking
    blink_sel = 1'b1;
    grp_freq = 8'd2; grp_duty = 8'h80; tick(200);
    grp_freq = 8'd0; grp_duty = 8'h40; tick(100);
    grp_freq = 8'd9; grp_duty = 8'hC0; tick(400);

    // R9 sleep holds phases
    sleep = 1'b1; tick(2);
    chk("R9", &led_n, 1'b1);
    tick(50);
    sleep = 1'b0; tick(300);

    blink_sel = 1'b0; grp_duty = 8'h60; tick(1100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule